// File: doc/BRIEF.md
# Binary Rate Multiplier

This block turns a clock into a sparse pulse train whose average density is set by a binary rate word. It runs a window of 2^W enabled clocks. Within each window it emits exactly N single-cycle pulses, where N is the W-bit rate word, so the average output rate is N/2^W of the clock rate.

A free-running binary counter steps once per enabled clock. Each counter value is classified by the position of its lowest set bit. Values whose lowest set bit is bit 0 occur every second cycle. Values whose lowest set bit is bit 1 occur every fourth cycle, and so on. The most significant rate bit selects the most frequent class, which keeps the pulses spread across the window instead of grouped together.

The block can act as a programmable fractional divider. A terminal-count flag marks the last count of each window, so other logic can synchronise to it.

Top module: `binary_rate_mult`

## Requirements
- R1: The internal W-bit counter advances by exactly one on every rising edge where clear is inactive and enable is high, wrapping from all ones to zero. After a clear, the terminal-count flag therefore reappears after exactly 2^W-1 enabled edges.
- R2: After an enabled edge that moves the counter to a value v, the pulse output is high for the following cycle exactly when v is nonzero and rate bit W-1-t is set, where t is the index of the lowest set bit of v. The value v = 0 never gives a pulse.
- R3: Over any 2^W consecutive enabled edges that start from counter value zero with a constant rate word N, the pulse output is high in exactly N cycles.
- R4: With a rate word of zero the pulse output never goes high.
- R5: With a rate word of all ones, the pulse output is high in every cycle of a window except one, namely the cycle after the counter wraps to zero.
- R6: The terminal-count flag equals the enable input ANDed with the counter being all ones. It is therefore high for a single cycle per window while counting runs.
- R7: An edge with enable low and clear inactive leaves the counter unchanged and drives the pulse output low for the next cycle.
- R8: An edge with the active-low clear low sets the counter to zero and drives the pulse output low for the next cycle, regardless of enable.
- R9: A new rate word is used at the next edge. The counter is not restarted by a rate change.
- R10: The width W is a parameter with default 6. Widths below 1 are rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| clr_n_i | input | 1 | Synchronous clear, active low |
| en_i | input | 1 | Count enable |
| rate_i | input | W | Rate word N, pulses per window |
| pulse_o | output | 1 | Registered single-cycle output pulse |
| tc_o | output | 1 | Terminal count: counter all ones and enable high |

## Verification
The pulse output is one register stage behind its inputs. A pulse caused by the edge at which enable, clear and the rate word are sampled shows up in the cycle after that edge. The bench drives inputs at the falling edge, lets one rising edge pass, and compares at the next falling edge. The terminal-count flag depends on the counter register and on the present enable level. It is compared in that same half cycle, while the enable that was driven is still held. Window totals are summed over 2^W consecutive steps that begin right after a clear.

// File: rtl/brm_pkg.sv
package brm_pkg;

   // Default width of the rate word and of the window counter.
   localparam int unsigned BRM_DEF_W = 6;

   // Rate bit index that is selected by a lowest-set-bit position k.
   function automatic int unsigned brm_rate_idx(input int unsigned w, input int unsigned k);
      return w - 1 - k;
   endfunction

endpackage

// File: rtl/brm_counter.sv
module brm_counter #(
   parameter int unsigned W = brm_pkg::BRM_DEF_W
) (
   input  logic         clk_i,
   input  logic         clr_n_i,
   input  logic         en_i,
   output logic [W-1:0] cnt_o,
   output logic [W-1:0] cnt_nxt_o,
   output logic         full_o
);
   localparam logic [W-1:0] ONE  = W'(1);
   localparam logic [W-1:0] ALL1 = {W{1'b1}};

   logic [W-1:0] cnt_q;

   assign cnt_nxt_o = cnt_q + ONE;
   assign full_o    = (cnt_q == ALL1);
   assign cnt_o     = cnt_q;

   always_ff @(posedge clk_i) begin
      if (!clr_n_i) begin
         cnt_q <= '0;
      end else if (en_i) begin
         cnt_q <= cnt_nxt_o;
      end
   end
endmodule

// File: rtl/brm_decode.sv
module brm_decode #(
   parameter int unsigned W = brm_pkg::BRM_DEF_W
) (
   input  logic [W-1:0] val_i,
   input  logic [W-1:0] rate_i,
   output logic         hit_o
);
   // sel[k] is high when bit k is the lowest set bit of val_i.
   logic [W-1:0] sel;
   logic [W-1:0] gated;

   for (genvar k = 0; k < W; k++) begin : g_cls
      if (k == 0) begin : g_lsb
         assign sel[k] = val_i[0];
      end else begin : g_upper
         assign sel[k] = val_i[k] & ~(|val_i[k-1:0]);
      end
      assign gated[k] = sel[k] & rate_i[brm_pkg::brm_rate_idx(W, k)];
   end

   assign hit_o = |gated;
endmodule

// File: rtl/brm_pulse_reg.sv
module brm_pulse_reg (
   input  logic clk_i,
   input  logic clr_n_i,
   input  logic en_i,
   input  logic hit_i,
   output logic pulse_o
);
   logic pulse_q;

   always_ff @(posedge clk_i) begin
      if (!clr_n_i) begin
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= en_i & hit_i;
      end
   end

   assign pulse_o = pulse_q;
endmodule

// File: rtl/binary_rate_mult.sv
module binary_rate_mult #(
   parameter int unsigned W = brm_pkg::BRM_DEF_W
) (
   input  logic         clk_i,
   input  logic         clr_n_i,
   input  logic         en_i,
   input  logic [W-1:0] rate_i,
   output logic         pulse_o,
   output logic         tc_o
);
   // R10: width legality
   if (W < 1) begin : g_bad_w
      $error("binary_rate_mult: W must be at least 1");
   end

   logic [W-1:0] cnt_q;
   logic [W-1:0] cnt_nxt;
   logic         full;
   logic         hit;

   brm_counter #(.W(W)) u_cnt (
      .clk_i     (clk_i),
      .clr_n_i   (clr_n_i),
      .en_i      (en_i),
      .cnt_o     (cnt_q),
      .cnt_nxt_o (cnt_nxt),
      .full_o    (full)
   );

   // Decode the value the counter is about to take.
   brm_decode #(.W(W)) u_dec (
      .val_i  (cnt_nxt),
      .rate_i (rate_i),
      .hit_o  (hit)
   );

   brm_pulse_reg u_pr (
      .clk_i   (clk_i),
      .clr_n_i (clr_n_i),
      .en_i    (en_i),
      .hit_i   (hit),
      .pulse_o (pulse_o)
   );

   assign tc_o = en_i & full;
endmodule

// File: rtl/brm_checker.sv
module brm_checker #(
   parameter int unsigned W = brm_pkg::BRM_DEF_W
) (
   input logic         clk_i,
   input logic         clr_n_i,
   input logic         en_i,
   input logic [W-1:0] rate_i,
   input logic         pulse_o,
   input logic         tc_o,
   input logic [W-1:0] cnt_q
);
   logic armed_q = 1'b0;

   always_ff @(posedge clk_i) begin
      if (!clr_n_i) armed_q <= 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!armed_q)
      (clr_n_i && en_i) |=> (cnt_q == $past(cnt_q) + W'(1))); // R1

   AST_TC_WRAP: assert property (@(posedge clk_i) disable iff (!armed_q)
      (tc_o && clr_n_i) |=> (cnt_q == '0)); // R6

   AST_ZERO_RATE_QUIET: assert property (@(posedge clk_i) disable iff (!armed_q)
      pulse_o |-> ($past(rate_i) != '0)); // R4

   AST_NO_PULSE_UNLESS_RUN: assert property (@(posedge clk_i) disable iff (!armed_q)
      pulse_o |-> ($past(en_i) && $past(clr_n_i))); // R7

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!armed_q)
      (clr_n_i && !en_i) |=> ($stable(cnt_q) && !pulse_o)); // R7

   AST_CLEAR_ZEROES: assert property (@(posedge clk_i) disable iff (!armed_q)
      (!clr_n_i) |=> ((cnt_q == '0) && !pulse_o)); // R8

   AST_ZERO_VALUE_SILENT: assert property (@(posedge clk_i) disable iff (!armed_q)
      (cnt_q == '0) |-> !pulse_o); // R2
endmodule

bind binary_rate_mult brm_checker #(.W(W)) u_brm_chk (
   .clk_i   (clk_i),
   .clr_n_i (clr_n_i),
   .en_i    (en_i),
   .rate_i  (rate_i),
   .pulse_o (pulse_o),
   .tc_o    (tc_o),
   .cnt_q   (cnt_q)
);

// File: tb/binary_rate_mult_tb_top.sv
module binary_rate_mult_tb_top;
   localparam int unsigned W       = 6;
   localparam int unsigned WIN     = 1 << W;
   localparam time         CLK_PER = 10ns;
   localparam int          WDOG    = 150000;

   logic         clk = 1'b0;
   logic         clr_n = 1'b0;
   logic         en = 1'b0;
   logic [W-1:0] rate = '0;
   logic         pulse;
   logic         tc;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [W-1:0] mc = '0;
   logic         mp = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   binary_rate_mult #(.W(W)) dut_i (
      .clk_i   (clk),
      .clr_n_i (clr_n),
      .en_i    (en),
      .rate_i  (rate),
      .pulse_o (pulse),
      .tc_o    (tc)
   );

   // Expected pulse for counter value v (R2).
   function automatic logic exp_hit(input logic [W-1:0] v, input logic [W-1:0] r);
      for (int k = 0; k < W; k++) begin
         if (v[k]) return r[W-1-k];
      end
      return 1'b0;
   endfunction

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic chk_int(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // One clock step: drive at negedge, model the edge, compare at next negedge.
   task automatic step(input logic e, input logic c, input logic [W-1:0] r, input string req);
      en = e; clr_n = c; rate = r;
      @(posedge clk);
      if (!c) begin
         mc = '0; mp = 1'b0;
      end else if (e) begin
         mc = mc + W'(1); mp = exp_hit(mc, r);
      end else begin
         mp = 1'b0;
      end
      @(negedge clk);
      chk({req, " pulse"}, pulse, mp);
      chk({req, " tc"}, tc, e & (mc == {W{1'b1}}));
   endtask

   task automatic window_count(input logic [W-1:0] r, input string req);
      int n = 0;
      step(1'b0, 1'b0, r, "R8");
      for (int i = 0; i < WIN; i++) begin
         step(1'b1, 1'b1, r, req);
         if (pulse) n++;
      end
      chk_int({req, " window count"}, n, int'(r));
   endtask

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      int tcs;
      int dummy;
      dummy = $urandom(32'h5eed_1234);
      @(negedge clk);
      step(1'b0, 1'b0, '0, "R8 reset");
      step(1'b0, 1'b0, '0, "R8 reset");
      chk("R8 reset pulse low", pulse, 1'b0);

      // R1: tc after exactly 2^W-1 enabled edges
      tcs = 0;
      for (int i = 0; i < WIN - 1; i++) begin
         step(1'b1, 1'b1, 6'b100000, "R1 R2");
         if (tc) tcs++;
      end
      chk("R1 tc at all ones", tc, 1'b1);
      chk_int("R6 single tc", tcs, 1);
      step(1'b1, 1'b1, 6'b100000, "R1 wrap");
      chk("R6 tc gone after wrap", tc, 1'b0);

      // R4, R5, R3 directed windows
      window_count('0, "R4");
      window_count({W{1'b1}}, "R5");
      window_count(6'd1, "R3");
      window_count(6'd32, "R3");
      window_count(6'd21, "R3");
      window_count(6'd42, "R3");

      // R7: enable low holds counter; tc follows enable
      step(1'b0, 1'b0, {W{1'b1}}, "R8");
      for (int i = 0; i < WIN - 1; i++) step(1'b1, 1'b1, {W{1'b1}}, "R7 prep");
      step(1'b0, 1'b1, {W{1'b1}}, "R7 idle");
      chk("R7 pulse low while idle", pulse, 1'b0);
      chk("R6 tc low with en low", tc, 1'b0);
      step(1'b0, 1'b1, {W{1'b1}}, "R7 idle");
      en = 1'b1;
      #1;
      chk("R7 counter held at all ones", tc, 1'b1);

      // R8: clear wins over enable
      step(1'b1, 1'b0, {W{1'b1}}, "R8 clear over enable");
      chk("R8 pulse low after clear", pulse, 1'b0);

      // R9: rate change mid window, no restart
      for (int i = 0; i < 10; i++) step(1'b1, 1'b1, 6'd0, "R9");
      step(1'b1, 1'b1, 6'b100000, "R9 new rate");
      chk("R9 new rate applied at next edge", pulse, 1'b1);

      // Random mix (R1, R2, R6, R7, R8, R9)
      for (int i = 0; i < 4000; i++) begin
         logic e, c;
         logic [W-1:0] r;
         e = ($urandom % 8) != 0;
         c = ($urandom % 64) != 0;
         r = W'($urandom);
         step(e, c, r, "R2 random");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule